// File: doc/BRIEF.md
# Looping operand pattern generator

This block supplies test operands to a wide adder. Every bit of operand A, every bit of operand B and the carry-in has its own small recirculating ring, giving 2*OP_W+1 independent lanes. While the block is in load mode, a host writes a short list of operand sets, one complete set (A, B, carry-in) per write strobe. The sets are appended behind the tokens already held in the rings.

In run mode the rings replay the stored list on a valid/ready output channel without any further help from the host. The set at the head of the rings stays on the outputs until a handshake (valid and ready both high) rotates every ring by one token. After the last stored set the sequence wraps to the first, so the output repeats with a period equal to the number of stored sets.

Each ring has RING_STAGES positions. Two of them are always left empty as spacing, so a ring holds at most RING_STAGES-2 live tokens (7 with the defaults). The run/stop input is registered into an internal mode, and a synchronous reset empties every ring and returns the block to load mode.

Top module: `opgen_pattern_src`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sets` reads 0, `ovf` reads 0 and `out_valid` is low, whatever the level of `run`.
- R2: A cycle with `ld_wr` high, internal mode load and fewer than 7 stored sets stores (`ld_a`, `ld_b`, `ld_cin`) behind the existing sets, and `sets` reads one higher on the next cycle.
- R3: A cycle with `ld_wr` high in load mode while 7 sets are stored is rejected: `sets` stays at 7, the stored sequence is unchanged and `ovf` rises on the next cycle and stays high until reset.
- R4: `out_valid` is high exactly when the internal mode is run and at least one set is stored; entering run with zero stored sets keeps `out_valid` low.
- R5: On entering run, the outputs present the oldest stored set first, and they move to the next stored set at each cycle where `out_valid` and `out_ready` are both high.
- R6: After the newest stored set has been handed over, the next output is the oldest again, so the output sequence repeats with period `sets` (1 to 7); with one set stored the outputs never change.
- R7: While `out_valid` is high and `out_ready` is low, `out_a`, `out_b` and `out_cin` keep their values.
- R8: `ld_wr` has no effect while the internal mode is run: `sets` is unchanged and the output sequence continues as though no write had happened.
- R9: The internal mode takes the value of `run` (1 = run, 0 = load) one cycle after it is sampled. Stopping lowers `out_valid` and keeps the ring position, so resuming continues from the set that was at the head when the block stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Mode request: 1 = run, 0 = load |
| ld_wr | input | 1 | Write strobe for one operand set |
| ld_a | input | OP_W (64) | Operand A of the set being written |
| ld_b | input | OP_W (64) | Operand B of the set being written |
| ld_cin | input | 1 | Carry-in of the set being written |
| sets | output | $clog2(RING_STAGES+1) (4) | Number of stored sets |
| ovf | output | 1 | Sticky flag: a write was rejected because the rings were full |
| out_valid | output | 1 | An operand set is being offered |
| out_ready | input | 1 | The downstream adder accepts the offered set |
| out_a | output | OP_W (64) | Operand A at the head of the rings |
| out_b | output | OP_W (64) | Operand B at the head of the rings |
| out_cin | output | 1 | Carry-in at the head of the rings |

## Verification
A corrupted token in one lane shows as a single wrong bit in one operand. That bit reappears once per period of `sets` handshakes, so a scoreboard that compares every accepted set against an independent rotating model detects it within one full period. A wrong fill count shows directly on `sets`, and also as a period that is too short or too long, with the wrong set coming back at the wrap. A wrong mode shows as `out_valid` rising with zero stored sets, or as a write during run that changes `sets`.

// File: rtl/opgen_pkg.sv
package opgen_pkg;

    typedef enum logic {
        MODE_LOAD = 1'b0,
        MODE_RUN  = 1'b1
    } opgen_mode_e;

    // Positions kept empty in every ring so that tokens have room to move
    localparam int unsigned RING_SPACERS = 2;

    function automatic int unsigned ring_capacity(input int unsigned stages);
        return stages - RING_SPACERS;
    endfunction

endpackage

// File: rtl/opgen_lane_ring.sv
module opgen_lane_ring #(
    parameter int unsigned STAGES = 9,
    parameter int unsigned CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] fill,
    input  logic             wr_en,
    input  logic             wr_bit,
    input  logic             adv,
    output logic             head
);

    logic [STAGES-1:0] ring_d, ring_q;

    always_comb begin
        ring_d = ring_q;
        if (wr_en) begin
            // append at the first empty position
            for (int i = 0; i < STAGES; i++) begin
                if (i == int'(fill)) ring_d[i] = wr_bit;
            end
        end else if (adv) begin
            // rotate the occupied part of the loop by one position
            for (int i = 0; i < STAGES; i++) begin
                if (i + 1 == int'(fill)) begin
                    ring_d[i] = ring_q[0];
                end else if (i + 1 < int'(fill)) begin
                    ring_d[i] = ring_q[(i + 1) % STAGES];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ring_q <= '0;
        else     ring_q <= ring_d;
    end

    assign head = ring_q[0];

endmodule

// File: rtl/opgen_ring_bank.sv
module opgen_ring_bank #(
    parameter int unsigned LANES  = 129,
    parameter int unsigned STAGES = 9,
    parameter int unsigned CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] fill,
    input  logic             wr_en,
    input  logic [LANES-1:0] wr_bits,
    input  logic             adv,
    output logic [LANES-1:0] heads
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        opgen_lane_ring #(
            .STAGES(STAGES),
            .CNT_W (CNT_W)
        ) u_ring (
            .clk   (clk),
            .rst   (rst),
            .fill  (fill),
            .wr_en (wr_en),
            .wr_bit(wr_bits[g]),
            .adv   (adv),
            .head  (heads[g])
        );
    end

endmodule

// File: rtl/opgen_seq_ctl.sv
module opgen_seq_ctl
    import opgen_pkg::*;
#(
    parameter int unsigned CAP   = 7,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_req,
    input  logic             wr_req,
    input  logic             out_ready,
    output logic [CNT_W-1:0] fill,
    output logic             ovf,
    output logic             wr_en,
    output logic             adv,
    output logic             valid
);

    localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAP);

    typedef struct packed {
        opgen_mode_e      mode;
        logic [CNT_W-1:0] fill;
        logic             ovf;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic in_load;
    logic full;

    assign in_load = (ctl_q.mode == MODE_LOAD);
    assign full    = (ctl_q.fill >= CAP_V);
    assign wr_en   = in_load && wr_req && !full;
    assign valid   = (ctl_q.mode == MODE_RUN) && (ctl_q.fill != '0);
    assign adv     = valid && out_ready;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.mode = run_req ? MODE_RUN : MODE_LOAD;
        if (wr_en) begin
            ctl_d.fill = ctl_q.fill + CNT_W'(1);
        end
        if (in_load && wr_req && full) begin
            ctl_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.mode <= MODE_LOAD;
            ctl_q.fill <= '0;
            ctl_q.ovf  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign fill = ctl_q.fill;
    assign ovf  = ctl_q.ovf;

endmodule

// File: rtl/opgen_pattern_src.sv
module opgen_pattern_src
    import opgen_pkg::*;
#(
    parameter int unsigned OP_W        = 64,
    parameter int unsigned RING_STAGES = 9
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             run,
    input  logic                             ld_wr,
    input  logic [OP_W-1:0]                  ld_a,
    input  logic [OP_W-1:0]                  ld_b,
    input  logic                             ld_cin,
    output logic [$clog2(RING_STAGES+1)-1:0] sets,
    output logic                             ovf,
    output logic                             out_valid,
    input  logic                             out_ready,
    output logic [OP_W-1:0]                  out_a,
    output logic [OP_W-1:0]                  out_b,
    output logic                             out_cin
);

    localparam int unsigned LANES = 2 * OP_W + 1;
    localparam int unsigned CAP   = ring_capacity(RING_STAGES);
    localparam int unsigned CNT_W = $clog2(RING_STAGES + 1);

    logic [CNT_W-1:0] fill;
    logic             wr_en;
    logic             adv;
    logic [LANES-1:0] wr_bits;
    logic [LANES-1:0] heads;

    // lane order: carry-in on top, then B, then A
    assign wr_bits = {ld_cin, ld_b, ld_a};

    opgen_seq_ctl #(
        .CAP  (CAP),
        .CNT_W(CNT_W)
    ) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .run_req  (run),
        .wr_req   (ld_wr),
        .out_ready(out_ready),
        .fill     (fill),
        .ovf      (ovf),
        .wr_en    (wr_en),
        .adv      (adv),
        .valid    (out_valid)
    );

    opgen_ring_bank #(
        .LANES (LANES),
        .STAGES(RING_STAGES),
        .CNT_W (CNT_W)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .fill   (fill),
        .wr_en  (wr_en),
        .wr_bits(wr_bits),
        .adv    (adv),
        .heads  (heads)
    );

    assign sets    = fill;
    assign out_a   = heads[OP_W-1:0];
    assign out_b   = heads[2*OP_W-1:OP_W];
    assign out_cin = heads[LANES-1];

endmodule

// File: rtl/opgen_pattern_chk.sv
module opgen_pattern_chk #(
    parameter int unsigned OP_W  = 64,
    parameter int unsigned CNT_W = 4,
    parameter int unsigned CAP   = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             ld_wr,
    input logic [CNT_W-1:0] sets,
    input logic             ovf,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OP_W-1:0]  out_a,
    input logic [OP_W-1:0]  out_b,
    input logic             out_cin
);

    localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAP);

    // R4: no offer without stored sets
    assert_valid_needs_sets_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (sets != '0));

    // R3: the fill count never passes the ring capacity
    assert_fill_capped_R3: assert property (@(posedge clk) disable iff (rst)
        sets <= CAP_V);

    // R2: an accepted write raises the count by one
    assert_append_counts_R2: assert property (@(posedge clk) disable iff (rst)
        (ld_wr && !$past(run) && sets < CAP_V) |=> (sets == $past(sets) + CNT_W'(1)));

    // R3: a write into full rings raises the flag
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (ld_wr && !$past(run) && sets == CAP_V) |=> (ovf && sets == CAP_V));

    // R3: the flag is sticky
    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    // R7: stalled offer holds its data
    assert_stall_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (!out_valid ||
            (out_a == $past(out_a) && out_b == $past(out_b) && out_cin == $past(out_cin))));

    // R8: in run mode the count does not move
    assert_run_keeps_sets_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && !$past(rst)) |=> $stable(sets));

endmodule

bind opgen_pattern_src opgen_pattern_chk #(
    .OP_W (OP_W),
    .CNT_W(CNT_W),
    .CAP  (CAP)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .ld_wr    (ld_wr),
    .sets     (sets),
    .ovf      (ovf),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_a    (out_a),
    .out_b    (out_b),
    .out_cin  (out_cin)
);

// File: tb/opgen_pattern_src_test.sv
module opgen_pattern_src_test;

    localparam int OP_W = 64;

    typedef struct packed {
        logic [OP_W-1:0] a;
        logic [OP_W-1:0] b;
        logic            c;
    } opset_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            run = 1'b0;
    logic            ld_wr = 1'b0;
    logic [OP_W-1:0] ld_a = '0;
    logic [OP_W-1:0] ld_b = '0;
    logic            ld_cin = 1'b0;
    logic [3:0]      sets;
    logic            ovf;
    logic            out_valid;
    logic            out_ready = 1'b0;
    logic [OP_W-1:0] out_a;
    logic [OP_W-1:0] out_b;
    logic            out_cin;

    int checks = 0;
    int fails  = 0;

    opset_t ring_m[$];   // expected ring contents, head first
    opset_t sb_q[$];     // expected accepted sets, in order

    always #10 clk = ~clk;

    opgen_pattern_src uut (
        .clk(clk), .rst(rst), .run(run), .ld_wr(ld_wr),
        .ld_a(ld_a), .ld_b(ld_b), .ld_cin(ld_cin),
        .sets(sets), .ovf(ovf), .out_valid(out_valid), .out_ready(out_ready),
        .out_a(out_a), .out_b(out_b), .out_cin(out_cin)
    );

    function automatic opset_t mkset(input int k);
        opset_t s;
        s.a = {32'hA5C3_0000 + 32'(k * 17), 32'h0F1E_2D3C ^ 32'(k * 977)};
        s.b = {32'h7766_5544 - 32'(k * 3), 32'h1357_9BDF + 32'(k << 8)};
        s.c = k[0];
        return s;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [OP_W-1:0] act,
                       input logic [OP_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_set(input opset_t s, input bit accept);
        @(posedge clk); #1;
        ld_wr = 1'b1; ld_a = s.a; ld_b = s.b; ld_cin = s.c;
        @(posedge clk); #1;
        ld_wr = 1'b0;
        if (accept) ring_m.push_back(s);
    endtask

    // driver: queue the expected sets, then accept n offers
    task automatic handshakes(input int n);
        for (int i = 0; i < n; i++) begin
            opset_t h;
            h = ring_m.pop_front();
            sb_q.push_back(h);
            ring_m.push_back(h);
        end
        out_ready = 1'b1;
        cycles(n);
        out_ready = 1'b0;
        chk(sb_q.size() == 0, "R5 all expected sets handed over", 64'(sb_q.size()), 64'd0);
    endtask

    // monitor: compare every accepted set against the scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R5 unexpected handshake", 64'd1, 64'd0);
            end else begin
                opset_t e;
                e = sb_q.pop_front();
                chk(out_a == e.a, "R5/R6 out_a", out_a, e.a);
                chk(out_b == e.b, "R5/R6 out_b", out_b, e.b);
                chk(out_cin == e.c, "R5/R6 out_cin", 64'(out_cin), 64'(e.c));
            end
        end
    end

    initial begin
        #(200000 * 20);
        chk(1'b0, "watchdog expired", 64'd1, 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        opset_t h;
        // R1: reset with run requested
        run = 1'b1;
        cycles(3);
        chk(sets == 0, "R1 sets in reset", 64'(sets), 64'd0);
        chk(!ovf, "R1 ovf in reset", 64'(ovf), 64'd0);
        chk(!out_valid, "R1 valid in reset", 64'(out_valid), 64'd0);
        run = 1'b0;
        rst = 1'b0;
        cycles(1);
        chk(sets == 0 && !out_valid && !ovf, "R1 first cycle after reset", 64'(sets), 64'd0);

        // R2: load three sets
        for (int k = 0; k < 3; k++) begin
            write_set(mkset(k), 1'b1);
            chk(sets == 4'(k + 1), "R2 sets after write", 64'(sets), 64'(k + 1));
        end

        // R9/R4: mode follows run one cycle later
        run = 1'b1;
        chk(!out_valid, "R9 valid before mode change", 64'(out_valid), 64'd0);
        cycles(1);
        chk(out_valid, "R4 valid in run with sets", 64'(out_valid), 64'd1);
        // R5/R7: first offer is the oldest set, held while stalled
        cycles(3);
        h = mkset(0);
        chk(out_a == h.a && out_b == h.b && out_cin == h.c, "R7 held oldest set", out_a, h.a);

        // R5/R6: wrap with period 3
        handshakes(10);

        // R8: write during run is ignored
        write_set(mkset(50), 1'b0);
        chk(sets == 3, "R8 sets unchanged by run write", 64'(sets), 64'd3);
        handshakes(4);

        // R9: stop keeps position
        run = 1'b0;
        cycles(2);
        chk(!out_valid, "R9 valid low after stop", 64'(out_valid), 64'd0);
        run = 1'b1;
        cycles(2);
        handshakes(2);
        run = 1'b0;
        cycles(2);

        // R2/R3: fill to capacity, then overflow
        for (int k = 3; k < 7; k++) write_set(mkset(k), 1'b1);
        chk(sets == 7, "R2 sets at capacity", 64'(sets), 64'd7);
        chk(!ovf, "R3 ovf still low at capacity", 64'(ovf), 64'd0);
        write_set(mkset(7), 1'b0);
        chk(ovf, "R3 ovf after rejected write", 64'(ovf), 64'd1);
        chk(sets == 7, "R3 sets stay at 7", 64'(sets), 64'd7);
        run = 1'b1;
        cycles(2);
        handshakes(15);
        chk(ovf, "R3 ovf sticky", 64'(ovf), 64'd1);

        // R4: run with zero sets after reset
        rst = 1'b1;
        cycles(2);
        rst = 1'b0;
        ring_m.delete();
        cycles(3);
        chk(!out_valid, "R4 valid low with zero sets", 64'(out_valid), 64'd0);
        chk(!ovf, "R1 ovf cleared by reset", 64'(ovf), 64'd0);

        // R6: period of one
        run = 1'b0;
        cycles(2);
        write_set(mkset(9), 1'b1);
        chk(sets == 1, "R2 single set stored", 64'(sets), 64'd1);
        run = 1'b1;
        cycles(2);
        handshakes(3);
        h = mkset(9);
        chk(out_a == h.a && out_b == h.b, "R6 single set repeats", out_a, h.a);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule